// File: doc/BRIEF.md
# Reversible-Gate Ripple Adder

This block adds two unsigned N-bit operands and a carry-in. It is built only from models of 3-input, 3-output reversible gates. Each gate maps its input triple to a distinct output triple, so no information is lost inside it. The netlist is purely combinational, and no arithmetic operator appears in it.

Each bit slice holds three gates. The first is an AND-XOR gate fed with (A, B, 0). It forms the propagate term A^B and the generate term A&B. The second is an AND-XOR gate fed with (P, Cin, 0). It forms the sum bit P^Cin and the product P&Cin. The third is a controlled-swap gate fed with (G, P&Cin, 1). Its middle output is the slice carry G | P&Cin.

Every slice ties off three constants and emits four garbage bits. Each slice's carry drives the next slice's carry-in. A wide garbage bus exposes all the leftover gate outputs, so the whole structure remains reversible.

Top module: `rev_ripple_adder`

## Requirements
- R1: {carry_out, sum} equals op_a + op_b + carry_in for every input combination, for any width N.
- R2: Garbage bit 4i is a copy of op_a[i]. Slice 0 occupies bits 3:0, slice 1 bits 7:4, and so on.
- R3: Garbage bit 4i+1 equals the propagate term op_a[i] ^ op_b[i].
- R4: Garbage bit 4i+2 equals the generate term op_a[i] & op_b[i]. It is never 1 in the same slice as the propagate bit.
- R5: Garbage bit 4i+3 equals (~G_i) | (P_i & C_i), where C_i is the carry entering slice i.
- R6: The AND-XOR gate maps (x,y,z) to (x, x^y, (x&y)^z). It is a bijection on its 8 input patterns.
- R7: The controlled-swap gate maps (x,y,z) to (x, x?z:y, x?y:z). It is a bijection, and every output triple has the same number of ones as its input triple.
- R8: With N=4 and carry_in=0, 1000+0011 gives sum 1011 with no carry-out, and 0111+0010 gives sum 1001 with no carry-out.
- R9: With all-ones operand A, zero operand B and carry_in=1, the carry ripples through every slice. The result is sum 0 with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into slice 0 |
| sum | output | N | Sum bits |
| carry_out | output | 1 | Carry out of slice N-1 |
| garbage | output | 4N | Leftover gate outputs, four per slice |

## Verification
The hardest case to reach from the ports is a carry that travels the full length of the chain. It only happens when every slice propagates and only slice 0 injects a carry. Random operands rarely produce it for N=8, so directed all-ones and alternating patterns with carry_in set are added.

The fourth garbage bit of each slice depends on the hidden per-slice carry. The bench rebuilds that carry from a masked partial sum and compares against it. Gate bijectivity cannot be seen through the adder's ports at all. For that reason, each gate is also driven on its own through all eight input patterns.

// File: rtl/rev_add_pkg.sv
package rev_add_pkg;

    // one wire triple of a 3x3 reversible gate
    typedef struct packed {
        logic x;
        logic y;
        logic z;
    } trio_t;

    localparam logic ANC_LO = 1'b0;
    localparam logic ANC_HI = 1'b1;
    localparam int   JUNK_PER_SLICE = 4;

    function automatic int ones3(input trio_t t);
        return int'(t.x) + int'(t.y) + int'(t.z);
    endfunction

endpackage

// File: rtl/rev_xa_gate.sv
module rev_xa_gate
    import rev_add_pkg::*;
(
    input  trio_t din,
    output trio_t dout
);
    // (x,y,z) -> (x, x^y, (x&y)^z)
    always_comb begin
        dout.x = din.x;
        dout.y = din.x ^ din.y;
        dout.z = (din.x & din.y) ^ din.z;
    end
endmodule

// File: rtl/rev_cswap_gate.sv
module rev_cswap_gate
    import rev_add_pkg::*;
(
    input  trio_t din,
    output trio_t dout
);
    // control x exchanges y and z when set
    always_comb begin
        dout.x = din.x;
        dout.y = din.x ? din.z : din.y;
        dout.z = din.x ? din.y : din.z;
    end
endmodule

// File: rtl/rev_add_slice.sv
module rev_add_slice
    import rev_add_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    output logic       s,
    output logic       cout,
    output logic [3:0] junk
);
    trio_t pg_in, pg_out;
    trio_t sm_in, sm_out;
    trio_t cy_in, cy_out;

    // first gate: propagate and generate
    assign pg_in = '{x: a, y: b, z: ANC_LO};
    rev_xa_gate u_pg (.din(pg_in), .dout(pg_out));

    // second gate: sum and P&C
    assign sm_in = '{x: pg_out.y, y: cin, z: ANC_LO};
    rev_xa_gate u_sm (.din(sm_in), .dout(sm_out));

    // swap gate: control G, data (P&C, 1) -> middle output is G | P&C
    assign cy_in = '{x: pg_out.z, y: sm_out.z, z: ANC_HI};
    rev_cswap_gate u_cy (.din(cy_in), .dout(cy_out));

    assign s    = sm_out.y;
    assign cout = cy_out.y;
    // [0] copy of a, [1] P, [2] G, [3] ~G | P&C
    assign junk = {cy_out.z, cy_out.x, sm_out.x, pg_out.x};
endmodule

// File: rtl/rev_ripple_adder.sv
module rev_ripple_adder
    import rev_add_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]                op_a,
    input  logic [N-1:0]                op_b,
    input  logic                        carry_in,
    output logic [N-1:0]                sum,
    output logic                        carry_out,
    output logic [JUNK_PER_SLICE*N-1:0] garbage
);
    localparam int JW = JUNK_PER_SLICE * N;

    logic [N:0] chain;

    assign chain[0] = carry_in;

    for (genvar i = 0; i < N; i++) begin : g_slice
        rev_add_slice u_slice (
            .a    (op_a[i]),
            .b    (op_b[i]),
            .cin  (chain[i]),
            .s    (sum[i]),
            .cout (chain[i+1]),
            .junk (garbage[JUNK_PER_SLICE*i +: JUNK_PER_SLICE])
        );
    end

    assign carry_out = chain[N];

    logic [JW-1:0] unused_width_ref;
    assign unused_width_ref = garbage;
endmodule

// File: rtl/rev_ripple_adder_chk.sv
module rev_ripple_adder_chk #(
    parameter int N = 8
) (
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic           carry_in,
    input logic [N-1:0]   sum,
    input logic           carry_out,
    input logic [4*N-1:0] garbage
);
    logic [N:0] ref_total;
    always_comb begin
        ref_total = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in};
        if (!$isunknown({op_a, op_b, carry_in})) begin
            AST_SUM_MATCH: assert ({carry_out, sum} == ref_total); // R1
            for (int i = 0; i < N; i++) begin
                AST_JUNK_COPY: assert (garbage[4*i] == op_a[i]); // R2
                AST_JUNK_PROP: assert (garbage[4*i+1] == (op_a[i] ^ op_b[i])); // R3
                AST_JUNK_GEN: assert (garbage[4*i+2] == (op_a[i] & op_b[i])); // R4
                AST_PG_EXCL: assert (!(garbage[4*i+1] && garbage[4*i+2])); // R4
                AST_TAIL_WHEN_NOGEN: assert (garbage[4*i+2] || garbage[4*i+3]); // R5
            end
        end
    end
endmodule

bind rev_ripple_adder rev_ripple_adder_chk #(.N(N)) u_chk (.*);

// File: tb/test_rev_ripple_adder.sv
module test_rev_ripple_adder;
    import rev_add_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // width 8 instance
    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [31:0] j8;
    rev_ripple_adder #(.N(8)) i_rev_ripple_adder (
        .op_a(a8), .op_b(b8), .carry_in(c8),
        .sum(s8), .carry_out(co8), .garbage(j8));

    // width 4 instance
    logic [3:0]  a4, b4, s4;
    logic        c4, co4;
    logic [15:0] j4;
    rev_ripple_adder #(.N(4)) i_rev_ripple_adder_n4 (
        .op_a(a4), .op_b(b4), .carry_in(c4),
        .sum(s4), .carry_out(co4), .garbage(j4));

    // standalone gates for bijection checks
    trio_t xa_in, xa_out, sw_in, sw_out;
    rev_xa_gate    i_xa (.din(xa_in), .dout(xa_out));
    rev_cswap_gate i_sw (.din(sw_in), .dout(sw_out));

    function automatic int exp_total(int a, int b, int c);
        return a + b + c;
    endfunction

    // carry entering slice i
    function automatic int carry_at(int a, int b, int c, int i);
        int m;
        m = (1 << i) - 1;
        return ((a & m) + (b & m) + c) >> i;
    endfunction

    function automatic logic [3:0] exp_junk(int a, int b, int c, int i);
        logic ai, bi, p, g, ci;
        ai = a[i]; bi = b[i];
        p = ai ^ bi; g = ai & bi;
        ci = carry_at(a, b, c, i)[0];
        return {(~g) | (p & ci), g, p, ai};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic vec8(input int a, input int b, input int c);
        @(posedge clk);
        a8 = a[7:0]; b8 = b[7:0]; c8 = c[0];
        @(negedge clk);
        chk("R1", int'({co8, s8}), exp_total(a & 255, b & 255, c & 1));
        for (int i = 0; i < 8; i++)
            chk("R2-R5 junk", int'(j8[4*i +: 4]),
                int'(exp_junk(a & 255, b & 255, c & 1, i)));
    endtask

    task automatic vec4(input int a, input int b, input int c);
        @(posedge clk);
        a4 = a[3:0]; b4 = b[3:0]; c4 = c[0];
        @(negedge clk);
        chk("R1", int'({co4, s4}), exp_total(a & 15, b & 15, c & 1));
        for (int i = 0; i < 4; i++)
            chk("R5 slice tail", int'(j4[4*i +: 4]),
                int'(exp_junk(a & 15, b & 15, c & 1, i)));
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        bit seen [8];
        a8 = '0; b8 = '0; c8 = 1'b0;
        a4 = '0; b4 = '0; c4 = 1'b0;
        xa_in = '0; sw_in = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: zero operands give zero sum
        @(negedge clk);
        chk("R1 idle", int'({co8, s8}), 0);

        // R8 directed examples
        @(posedge clk); a4 = 4'b1000; b4 = 4'b0011; c4 = 1'b0;
        @(negedge clk); chk("R8 1000+0011", int'({co4, s4}), 5'b01011);
        @(posedge clk); a4 = 4'b0111; b4 = 4'b0010; c4 = 1'b0;
        @(negedge clk); chk("R8 0111+0010", int'({co4, s4}), 5'b01001);

        // R9 full-length ripple
        @(posedge clk); a8 = 8'hFF; b8 = 8'h00; c8 = 1'b1;
        @(negedge clk); chk("R9 ripple", int'({co8, s8}), 9'h100);
        vec8(8'h00, 8'hFF, 1);
        vec8(8'hAA, 8'h55, 1);
        vec8(8'hFF, 8'hFF, 1);
        vec4(4'hF, 4'h0, 1);

        // R1 exhaustive at width 4
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 2; c++)
                    vec4(a, b, c);

        // R1..R5 random at width 8
        for (int k = 0; k < 3000; k++)
            vec8(int'($urandom & 32'hFF), int'($urandom & 32'hFF), int'($urandom & 1));

        // R6 bijection of the AND-XOR gate
        foreach (seen[k]) seen[k] = 1'b0;
        for (int v = 0; v < 8; v++) begin
            @(posedge clk); xa_in = trio_t'(v[2:0]);
            @(negedge clk);
            chk("R6 map", int'(xa_out),
                int'({v[2], v[2] ^ v[1], (v[2] & v[1]) ^ v[0]}));
            chk("R6 distinct", int'(seen[int'(xa_out)]), 0);
            seen[int'(xa_out)] = 1'b1;
        end

        // R7 bijection and ones conservation of the swap gate
        foreach (seen[k]) seen[k] = 1'b0;
        for (int v = 0; v < 8; v++) begin
            @(posedge clk); sw_in = trio_t'(v[2:0]);
            @(negedge clk);
            chk("R7 map", int'(sw_out),
                int'(v[2] ? {v[2], v[0], v[1]} : v[2:0]));
            chk("R7 ones", ones3(sw_out), int'(v[2]) + int'(v[1]) + int'(v[0]));
            chk("R7 distinct", int'(seen[int'(sw_out)]), 0);
            seen[int'(sw_out)] = 1'b1;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule